// File: doc/BRIEF.md
# Three-Bus 18-bit Register Datapath

This block is the arithmetic core of a small 18-bit processor. Two source buses, A and B, feed one parallel adder with an augend and an addend. The operands can come from any of five working registers: two accumulators, two index registers and the program counter. They can also come from the console-switch input or from a captured memory word. Bus B can take an immediate constant instead. A third bus, S, carries the adder output. It is the only way back into a register or out to the memory write port. Software, or a sequencer above this block, issues one command at a time. A command names the operation, the two sources and the destination. Instruction fetch, decode and the memory timing model are outside the block.

Commands enter on a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. Any `cmd_valid` while `cmd_ready` is low is ignored rather than held, so the issuer must keep a command presented until it sees ready. `done` pulses for one cycle once write-back and the flag update are visible. `skip` pulses together with `done` when an increment gives a non-negative result.

Top module: `dp18_three_bus`

## Requirements
- R1: After reset, all five registers and the flags Z, N and C read as zero. `cmd_ready` is 1, and `done`, `skip`, `mem_rd` and `mem_we` are 0.
- R2: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `cmd_ready` stays 0 until the cycle in which `done` is high. A `cmd_valid` while `cmd_ready` is 0 has no effect.
- R3: Let a command be accepted in cycle t. If it reads no memory operand, `done` is high in cycle t+2 only. If it reads memory, `mem_rd` is high in cycle t+1 only, `mem_rdata` is sampled at the end of that cycle, and `done` is high in cycle t+3.
- R4: Operation codes are 0 ADD, 1 SUB, 2 CMP, 3 AND and 4 OR. ADD gives S = A + B mod 2^18, and C is the carry out of bit 17. SUB gives S = A + ~B + 1, and C = 1 when A ≥ B unsigned.
- R5: CMP (code 2) sets the flags exactly as SUB does. It writes no register and raises no `mem_we`.
- R6: AND (3) and OR (4) put the bitwise result on bus S and clear C.
- R7: ADDK (5) and SUBK (6) use `cmd_imm` on bus B instead of the B source. CLR (7) forces bus A to zero and bus B to `cmd_imm`, so it loads the immediate value.
- R8: INC (8) adds one to the bus A source and writes the result to the destination. `skip` is high in the `done` cycle exactly when bit 17 of the result is 0.
- R9: Source codes on either bus are 0 acc1, 1 acc2, 2 idx1, 3 idx2, 4 program counter, 5 console switches and 6 memory data. Code 7 selects `cmd_imm` on bus B and reads zero on bus A.
- R10: Destination codes 0 to 4 write the matching register. Code 6 raises `mem_we` in cycle `done`−1 with `mem_wdata` equal to bus S. Codes 5 and 7 write nothing.
- R11: Z is set when the result is zero and N is bit 17 of the result. Flags change only for codes 0 to 8. Codes 9 to 15 complete with no write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_op | input | 4 | Operation code |
| cmd_src_a | input | 3 | Bus A source code |
| cmd_src_b | input | 3 | Bus B source code |
| cmd_dst | input | 3 | Destination code |
| cmd_imm | input | 18 | Immediate constant |
| console_sw | input | 18 | Console switch word (read only) |
| mem_rd | output | 1 | Memory operand capture cycle |
| mem_rdata | input | 18 | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 18 | Memory write data (bus S) |
| done | output | 1 | Command complete pulse |
| skip | output | 1 | Skip request from increment |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Sign flag |
| flag_c | output | 1 | Carry / no-borrow flag |

## Verification
The bench counts falling edges from the one where the command was taken. It expects `mem_rd` on the first edge for commands that read memory. It expects `done` on the second edge for register-only commands and on the third for memory commands. `mem_we` must appear on the edge just before `done`. Flags and `skip` are compared in the `done` cycle. Register contents are compared only through later commands that route a register to the memory write port. Every value is predicted by a bench model that applies the arithmetic rules to its own copy of the registers.

// File: rtl/dp18_pkg.sv
package dp18_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_ADDK = 4'd5,
    OP_SUBK = 4'd6,
    OP_CLR  = 4'd7,
    OP_INC  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_MEMRD,
    PH_EXEC
  } phase_e;

  localparam logic [2:0] SEL_AC1 = 3'd0;
  localparam logic [2:0] SEL_AC2 = 3'd1;
  localparam logic [2:0] SEL_IX1 = 3'd2;
  localparam logic [2:0] SEL_IX2 = 3'd3;
  localparam logic [2:0] SEL_PC  = 3'd4;
  localparam logic [2:0] SEL_CSW = 3'd5;
  localparam logic [2:0] SEL_MEM = 3'd6;
  localparam logic [2:0] SEL_IMM = 3'd7;

  function automatic logic op_known(input op_e op);
    return (op <= OP_INC);
  endfunction

  function automatic logic op_writes(input op_e op);
    return op_known(op) && (op != OP_CMP);
  endfunction

  function automatic logic op_uses_b_src(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) ||
           (op == OP_AND) || (op == OP_OR);
  endfunction

  function automatic logic op_uses_a_src(input op_e op);
    return op_known(op) && (op != OP_CLR);
  endfunction

  function automatic logic op_is_sub(input op_e op);
    return (op == OP_SUB) || (op == OP_CMP) || (op == OP_SUBK);
  endfunction

endpackage

// File: rtl/dp18_ctrl.sv
module dp18_ctrl
  import dp18_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [3:0]   cmd_op,
  input  logic [2:0]   cmd_src_a,
  input  logic [2:0]   cmd_src_b,
  input  logic [2:0]   cmd_dst,
  input  logic [W-1:0] cmd_imm,
  output op_e          q_op,
  output logic [2:0]   q_src_a,
  output logic [2:0]   q_src_b,
  output logic [2:0]   q_dst,
  output logic [W-1:0] q_imm,
  output logic         exec,
  output logic         mem_rd,
  output logic         done
);

  phase_e phase;
  logic   accept;
  logic   needs_mem;
  op_e    in_op;

  assign in_op     = op_e'(cmd_op);
  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign needs_mem = (op_uses_a_src(in_op) && cmd_src_a == SEL_MEM) ||
                     (op_uses_b_src(in_op) && cmd_src_b == SEL_MEM);
  assign exec      = (phase == PH_EXEC);
  assign mem_rd    = (phase == PH_MEMRD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      q_op    <= OP_ADD;
      q_src_a <= '0;
      q_src_b <= '0;
      q_dst   <= SEL_IMM;
      q_imm   <= '0;
      done    <= 1'b0;
    end else begin
      done <= exec;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            q_op    <= in_op;
            q_src_a <= cmd_src_a;
            q_src_b <= cmd_src_b;
            q_dst   <= cmd_dst;
            q_imm   <= cmd_imm;
            phase   <= needs_mem ? PH_MEMRD : PH_EXEC;
          end
        end
        PH_MEMRD: phase <= PH_EXEC;
        PH_EXEC:  phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_memrd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!mem_rd && !done));

endmodule

// File: rtl/dp18_regbank.sv
module dp18_regbank
  import dp18_pkg::*;
#(
  parameter int W    = 18,
  parameter int NREG = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   src_a,
  input  logic [2:0]   src_b,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] console,
  input  logic [W-1:0] mem_rdata,
  input  logic         mdr_load,
  input  logic         we,
  input  logic [2:0]   wsel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] bus_a,
  output logic [W-1:0] bus_b
);

  logic [W-1:0] regs [NREG];
  logic [W-1:0] mdr;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && wsel == 3'(g))
        regs[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mdr <= '0;
    else if (mdr_load)
      mdr <= mem_rdata;
  end

  always_comb begin
    bus_a = '0;
    for (int i = 0; i < NREG; i++)
      if (src_a == 3'(i)) bus_a = regs[i];
    if (src_a == SEL_CSW) bus_a = console;
    if (src_a == SEL_MEM) bus_a = mdr;
  end

  always_comb begin
    bus_b = imm;
    for (int i = 0; i < NREG; i++)
      if (src_b == 3'(i)) bus_b = regs[i];
    if (src_b == SEL_CSW) bus_b = console;
    if (src_b == SEL_MEM) bus_b = mdr;
  end

endmodule

// File: rtl/dp18_alu.sv
module dp18_alu
  import dp18_pkg::*;
#(
  parameter int W = 18
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         cout
);

  logic         sub;
  logic [W-1:0] b_x;
  logic [W:0]   ext;

  assign sub = op_is_sub(op);
  assign b_x = sub ? ~b : b;
  assign ext = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, sub};

  always_comb begin
    unique case (op)
      OP_AND: begin
        s    = a & b;
        cout = 1'b0;
      end
      OP_OR: begin
        s    = a | b;
        cout = 1'b0;
      end
      OP_ADD, OP_SUB, OP_CMP, OP_ADDK, OP_SUBK, OP_CLR, OP_INC: begin
        s    = ext[W-1:0];
        cout = ext[W];
      end
      default: begin
        s    = '0;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dp18_three_bus.sv
module dp18_three_bus
  import dp18_pkg::*;
#(
  parameter int W    = 18,
  parameter int NREG = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [3:0]   cmd_op,
  input  logic [2:0]   cmd_src_a,
  input  logic [2:0]   cmd_src_b,
  input  logic [2:0]   cmd_dst,
  input  logic [W-1:0] cmd_imm,
  input  logic [W-1:0] console_sw,
  output logic         mem_rd,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  output logic         done,
  output logic         skip,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_c
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  op_e          q_op;
  logic [2:0]   q_src_a, q_src_b, q_dst;
  logic [W-1:0] q_imm;
  logic         exec;
  logic [W-1:0] bus_a_raw, bus_b_raw, bus_a, bus_b, bus_s;
  logic         carry;
  logic         wr_ok, reg_we;

  dp18_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .cmd_dst(cmd_dst), .cmd_imm(cmd_imm),
    .q_op(q_op), .q_src_a(q_src_a), .q_src_b(q_src_b), .q_dst(q_dst),
    .q_imm(q_imm), .exec(exec), .mem_rd(mem_rd), .done(done)
  );

  dp18_regbank #(.W(W), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .src_a(q_src_a), .src_b(q_src_b), .imm(q_imm),
    .console(console_sw), .mem_rdata(mem_rdata), .mdr_load(mem_rd),
    .we(reg_we), .wsel(q_dst), .wdata(bus_s),
    .bus_a(bus_a_raw), .bus_b(bus_b_raw)
  );

  always_comb begin
    bus_a = (q_op == OP_CLR) ? '0 : bus_a_raw;
    unique case (q_op)
      OP_ADDK, OP_SUBK, OP_CLR: bus_b = q_imm;
      OP_INC:                   bus_b = ONE;
      default:                  bus_b = bus_b_raw;
    endcase
  end

  dp18_alu #(.W(W)) u_alu (
    .op(q_op), .a(bus_a), .b(bus_b), .s(bus_s), .cout(carry)
  );

  assign wr_ok     = exec && op_writes(q_op);
  assign reg_we    = wr_ok && (q_dst <= SEL_PC);
  assign mem_we    = wr_ok && (q_dst == SEL_MEM);
  assign mem_wdata = bus_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
      skip   <= 1'b0;
    end else begin
      skip <= exec && (q_op == OP_INC) && !bus_s[W-1];
      if (exec && op_known(q_op)) begin
        flag_z <= (bus_s == '0);
        flag_n <= bus_s[W-1];
        flag_c <= carry;
      end
    end
  end

  assert_skip_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> done);

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (q_op != OP_CMP));

  assert_memwe_before_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> done);

  assert_logic_clears_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (q_op == OP_AND || q_op == OP_OR)) |=> !flag_c);

  assert_flags_hold_unknown_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !op_known(q_op)) |=> ($stable(flag_z) && $stable(flag_n) && $stable(flag_c)));

endmodule

// File: tb/tb_dp18_three_bus.sv
`timescale 1ns/1ps
module tb_dp18_three_bus;

  localparam logic [3:0] ADD = 0, SUB = 1, CMP = 2, AND_ = 3, OR_ = 4,
                         ADDK = 5, SUBK = 6, CLR = 7, INC = 8;
  localparam logic [17:0] M = 18'h3FFFF;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = 0;
  logic [2:0]  cmd_src_a = 0, cmd_src_b = 0, cmd_dst = 0;
  logic [17:0] cmd_imm = 0;
  logic [17:0] console_sw = 0;
  logic        mem_rd;
  logic [17:0] mem_rdata = 0;
  logic        mem_we;
  logic [17:0] mem_wdata;
  logic        done, skip, flag_z, flag_n, flag_c;

  int checks = 0;
  int fails  = 0;

  logic [17:0] mreg [0:4];
  logic        fz = 0, fn = 0, fc = 0;

  always #2.5 clk = ~clk;

  dp18_three_bus dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .cmd_dst(cmd_dst), .cmd_imm(cmd_imm), .console_sw(console_sw),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .done(done), .skip(skip),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] srcv(input logic [2:0] c, input bit on_b,
                                       input logic [17:0] imm);
    if (c <= 4) return mreg[c];
    if (c == 5) return console_sw;
    if (c == 6) return mem_rdata;
    return on_b ? imm : 18'h0;
  endfunction

  task automatic run(input logic [3:0] op, input logic [2:0] sa, sb, dst,
                     input logic [17:0] imm, input bit inject, input string tag);
    logic [17:0] a, b, r;
    logic [18:0] ext;
    bit known, usesb, needmem, writes, e_c, e_skip;
    int n, done_at, rd_at, rd_cnt, we_cnt, ready_low;
    logic [17:0] wd;
    logic s_skip, s_z, s_n, s_c;
    known   = (op <= INC);
    usesb   = (op <= OR_);
    needmem = (known && op != CLR && sa == 6) || (usesb && sb == 6);
    writes  = known && op != CMP;
    a = (op == CLR) ? 18'h0 : srcv(sa, 0, imm);
    if (op == ADDK || op == SUBK || op == CLR) b = imm;
    else if (op == INC) b = 18'h1;
    else b = srcv(sb, 1, imm);
    if (op == SUB || op == CMP || op == SUBK) ext = {1'b0, a} + {1'b0, ~b & M} + 19'd1;
    else ext = {1'b0, a} + {1'b0, b};
    r = ext[17:0]; e_c = ext[18];
    if (op == AND_) begin r = a & b; e_c = 0; end
    if (op == OR_)  begin r = a | b; e_c = 0; end
    e_skip = (op == INC) && !r[17];

    @(negedge clk);
    chk(cmd_ready === 1'b1, {tag, " R2 ready idle"}, cmd_ready, 1);
    cmd_op = op; cmd_src_a = sa; cmd_src_b = sb; cmd_dst = dst; cmd_imm = imm;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    n = 1; done_at = 0; rd_at = 0; rd_cnt = 0; we_cnt = 0; wd = 0; ready_low = 1;
    s_skip = 0; s_z = 0; s_n = 0; s_c = 0;
    while (n < 10) begin
      if (mem_rd) begin rd_at = n; rd_cnt++; end
      if (mem_we) begin we_cnt++; wd = mem_wdata; end
      if (!done && cmd_ready) ready_low = 0;
      if (inject && n == 2) cmd_valid = 0;
      if (inject && n == 1) begin
        cmd_op = CLR; cmd_src_a = 0; cmd_src_b = 0; cmd_dst = 0;
        cmd_imm = 18'h15555; cmd_valid = 1;
      end
      if (done) begin
        done_at = n; s_skip = skip; s_z = flag_z; s_n = flag_n; s_c = flag_c;
        break;
      end
      @(negedge clk);
      n++;
    end
    cmd_valid = 0;
    chk(done_at == (needmem ? 3 : 2), {tag, " R3 done cycle"}, done_at, needmem ? 3 : 2);
    chk(ready_low == 1, {tag, " R2 ready low while busy"}, ready_low, 1);
    chk(rd_cnt == (needmem ? 1 : 0) && rd_at == (needmem ? 1 : 0),
        {tag, " R3 mem_rd cycle"}, rd_at, needmem ? 1 : 0);
    if (writes && dst == 6) begin
      chk(we_cnt == 1, {tag, " R10 mem_we count"}, we_cnt, 1);
      chk(wd == r, {tag, " R10 bus S value"}, wd, r);
    end else begin
      chk(we_cnt == 0, {tag, " R5 R10 no mem write"}, we_cnt, 0);
    end
    chk(s_skip == e_skip, {tag, " R8 skip"}, s_skip, e_skip);
    if (known) begin
      fz = (r == 0); fn = r[17]; fc = e_c;
    end
    chk({s_z, s_n, s_c} == {fz, fn, fc}, {tag, " R11 flags"}, {s_z, s_n, s_c}, {fz, fn, fc});
    if (writes && dst <= 4) mreg[dst] = r;
  endtask

  task automatic preload(input logic [17:0] v0, v1, v2, v3, v4);
    run(CLR, 3'd6, 0, 0, v0, 0, "R7 load acc1");
    run(CLR, 3'd5, 0, 1, v1, 0, "R7 load acc2");
    run(CLR, 0, 0, 2, v2, 0, "R7 load idx1");
    run(CLR, 0, 0, 3, v3, 0, "R7 load idx2");
    run(CLR, 0, 0, 4, v4, 0, "R7 load pc");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) mreg[i] = 0;
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1 && done === 0 && mem_rd === 0 && mem_we === 0 && skip === 0,
        "R1 reset outputs", {cmd_ready, done, mem_rd, mem_we, skip}, 5'b10000);
    chk({flag_z, flag_n, flag_c} === 3'b000, "R1 reset flags", {flag_z, flag_n, flag_c}, 0);
    rst_n = 1;
    for (int i = 0; i < 5; i++) run(OR_, 3'(i), 3'(i), 6, 0, 0, "R1 reset register");

    for (int set = 0; set < 2; set++) begin
      if (set == 0) begin
        console_sw = 18'h2AAAA; mem_rdata = 18'h15A5A;
        preload(18'h12345, 18'h2F0F0, 18'h00FFF, 18'h3C3C3, 18'h01234);
      end else begin
        console_sw = 18'h3FFFF; mem_rdata = 18'h00001;
        preload(18'h3FFFF, 18'h20000, 18'h1FFFF, 18'h00000, 18'h00001);
      end
      for (int op = 0; op <= 4; op++)
        for (int sa = 0; sa < 8; sa++)
          for (int sb = 0; sb < 8; sb++)
            run(4'(op), 3'(sa), 3'(sb), 6, 18'h0F00F, 0, "R4 R6 R9 sweep");
      for (int op = 5; op <= 8; op++)
        for (int sa = 0; sa < 8; sa++) begin
          run(4'(op), 3'(sa), 0, 6, 18'h20001, 0, "R7 R8 immediate sweep");
          run(4'(op), 3'(sa), 0, 6, 18'h00000, 0, "R7 R8 immediate zero");
        end
    end

    console_sw = 18'h2AAAA; mem_rdata = 18'h1FFFF;
    preload(18'h1FFFF, 18'h3FFFF, 18'h00000, 18'h00007, 18'h00100);
    run(ADD, 0, 1, 2, 0, 0, "R10 add to idx1");
    run(SUB, 4, 3, 4, 0, 0, "R10 sub to pc");
    run(CMP, 0, 1, 0, 0, 0, "R5 compare no write");
    run(CLR, 0, 0, 5, 18'h11111, 0, "R10 console dst ignored");
    run(OR_, 5, 5, 6, 0, 0, "R10 console unchanged");
    run(ADDK, 0, 0, 7, 18'h00005, 0, "R10 dst7 ignored");
    run(INC, 0, 0, 0, 0, 0, "R8 inc to negative");
    run(INC, 1, 0, 1, 0, 0, "R8 inc wrap to zero");
    run(INC, 2, 0, 2, 0, 0, "R8 inc zero");
    run(INC, 6, 0, 6, 0, 0, "R8 inc memory word");
    run(ADD, 1, 2, 3, 0, 1, "R2 busy inject reg op");
    run(ADD, 6, 0, 3, 0, 1, "R2 busy inject mem op");
    run(4'd9, 0, 1, 0, 0, 0, "R11 unknown op");
    run(4'd15, 6, 6, 6, 0, 0, "R11 unknown op mem");
    for (int i = 0; i < 5; i++) run(OR_, 3'(i), 3'(i), 6, 0, 0, "R10 final readback");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule